// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds the time of year in ten byte-wide registers and advances it once per second. A one-cycle `sec_tick` pulse, which comes from a prescaler outside the block, starts an update. The update warns readers through `busy` for a configurable number of cycles. It then steps through the fields one per cycle: seconds, minutes, hours, the day pair, month and year. A carry moves to the next field only when the lower field wraps.

Two run-time mode inputs set the coding and the hour format. `bin_mode` selects plain binary or packed BCD, and the choice applies to the time and alarm bytes alike. `hr24_mode` selects 24-hour or 12-hour hours. In 12-hour format, bit 7 of the hour byte marks PM. The stored bytes are never converted when a mode changes. While `hold` is high, ticks are ignored and software may load the time registers. The three alarm bytes can be written at any time. When an update completes, the block emits a one-cycle `upd_done` pulse. If seconds, minutes and hours then equal their alarm bytes, it also emits `alarm_hit`.

Top module: `tod_calendar_counter`

## Requirements
- R1: After reset, indices 0..5 and 9 read 0x00 and indices 6, 7 and 8 read 0x01. `busy`, `upd_done` and `alarm_hit` are low.
- R2: The register indices are: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 weekday, 7 day of month, 8 month, 9 year. `rd_data` shows the byte at `rd_idx` in the same cycle. Indices 10 to 15 read 0.
- R3: Seconds and minutes count 0..59 and wrap to 0 with a carry. In BCD the wrap is 0x59 to 0x00; in binary it is 0x3B to 0x00.
- R4: In 24-hour format, hours count 0..23. From 23, the hour goes to 0 and carries into the day.
- R5: In 12-hour format, bits 6:0 of the hour hold 1..12 and bit 7 marks PM. 11 goes to 12 and toggles PM; 12 goes to 1 with PM unchanged. Only 11 PM to 12 AM carries into the day. In BCD the sequence is 0x11 to 0x92, 0x92 to 0x81, 0x91 to 0x12, and 0x12 to 0x01.
- R6: On a day carry, the weekday steps 1..7 and wraps to 1. Day of month wraps to 1 after 31, 30 or 28, depending on the month: 28 for February, 30 for April, June, September and November, 31 otherwise. The wrap carries into the month. Month wraps 12 to 1 and carries into the year. Year wraps 99 to 0.
- R7: While `hold` is 1, `sec_tick` starts no update. Time-register writes (indices 0, 2, 4, 6..9) take effect only while `hold` is 1 and no update runs. Alarm writes (indices 1, 3, 5) take effect at any time.
- R8: `busy` rises in the cycle after an accepted tick. It stays high for `LEAD_CYC` cycles before any field changes, and stays high until the last field is written.
- R9: `upd_done` is high for exactly one cycle, the first cycle with `busy` low after an update.
- R10: `alarm_hit` pulses with `upd_done` when, after the update, seconds, minutes and hours equal bytes 1, 3 and 5. Otherwise it stays low.
- R11: Changing `bin_mode` or `hr24_mode` leaves every stored byte unchanged.
- R12: A `sec_tick` that arrives while `busy` is high is ignored and causes no second update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse that requests a one-second advance |
| bin_mode | input | 1 | 1 = binary coding, 0 = BCD coding |
| hr24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| hold | input | 1 | Freezes counting and opens the time registers for writes |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Register index to write |
| wr_data | input | 8 | Byte to write |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 8 | Byte at `rd_idx` |
| busy | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse at the end of each update |
| alarm_hit | output | 1 | One-cycle pulse when the alarm matches after an update |

## Verification
The bench builds the block with `LEAD_CYC = 3`, so the warning window lasts three cycles. Over that span the bench samples `busy` high while the seconds byte is still unchanged, and it fires a second tick inside the window to show that the tick is dropped. A lead of one cycle would leave almost no room to place that stray tick away from the edge where the update starts. Every other scenario uses the same build and covers both codings and both hour formats.

// File: rtl/tod_pkg.sv
// Package tod_pkg
// Shared sizes, register indices, update step encoding and the
// binary/BCD conversion helpers used by every tod_* module.
// Assumes values handled by the helpers stay below 100.
package tod_pkg;

    localparam int DATA_W  = 8;
    localparam int IDX_W   = 4;
    localparam int NREG    = 10;
    localparam int VAL_W   = 7;

    // Register indices (visible through the read/write ports)
    localparam int IX_SEC   = 0;
    localparam int IX_ASEC  = 1;
    localparam int IX_MIN   = 2;
    localparam int IX_AMIN  = 3;
    localparam int IX_HOUR  = 4;
    localparam int IX_AHOUR = 5;
    localparam int IX_DOW   = 6;
    localparam int IX_DOM   = 7;
    localparam int IX_MON   = 8;
    localparam int IX_YEAR  = 9;

    // Slots of the generic wrapping incrementers
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_DOM   = 2;
    localparam int F_MON   = 3;
    localparam int F_YR    = 4;
    localparam int FIELD_N = 5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LEAD, ST_SEC, ST_MIN, ST_HOUR,
        ST_DAY, ST_MON, ST_YEAR, ST_END
    } tod_step_e;

    // Decode a stored byte into its numeric value.
    function automatic logic [VAL_W-1:0] code_to_bin(
        input logic [DATA_W-1:0] v, input logic bin);
        if (bin) return v[VAL_W-1:0];
        return VAL_W'(v[7:4]) * VAL_W'(10) + VAL_W'(v[3:0]);
    endfunction

    // Encode a numeric value into the selected coding.
    function automatic logic [DATA_W-1:0] bin_to_code(
        input logic [VAL_W-1:0] b, input logic bin);
        if (bin) return {1'b0, b};
        return {4'(b / VAL_W'(10)), 4'(b % VAL_W'(10))};
    endfunction

endpackage

// File: rtl/tod_field_inc.sv
// Module tod_field_inc
// Combinational wrapping incrementer for one calendar field. It decodes
// the stored byte, adds one, and wraps to `lo` once the value has
// reached `hi`, then re-encodes the result in the active coding.
// Assumes lo <= hi < 100. Out-of-range inputs wrap at once.
module tod_field_inc
    import tod_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic              bin_mode,
    input  logic [VAL_W-1:0]  lo,
    input  logic [VAL_W-1:0]  hi,
    output logic [DATA_W-1:0] nxt,
    output logic              wrap
);

    logic [VAL_W-1:0] val;

    // Compute the next value and whether it wrapped.
    always_comb begin
        val = code_to_bin(cur, bin_mode);
        if (val >= hi) begin
            wrap = 1'b1;
            nxt  = bin_to_code(lo, bin_mode);
        end else begin
            wrap = 1'b0;
            nxt  = bin_to_code(val + VAL_W'(1), bin_mode);
        end
    end

endmodule

// File: rtl/tod_hour_inc.sv
// Module tod_hour_inc
// Combinational next-hour logic for both hour formats. In 24-hour
// format it wraps 23 to 0. In 12-hour format it keeps the PM flag in
// bit 7 and steps 11 to 12 with a flag toggle, and 12 to 1. A day carry
// is raised only on the 24-hour wrap or on 11 PM to 12 AM.
// Assumes the stored hour is valid for the active format.
module tod_hour_inc
    import tod_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic              bin_mode,
    input  logic              hr24_mode,
    output logic [DATA_W-1:0] nxt,
    output logic              day_carry
);

    logic [VAL_W-1:0] hval;
    logic [VAL_W-1:0] hnew;
    logic             pm_new;

    // Select the next hour code and the carry for the active format.
    always_comb begin
        hval      = '0;
        hnew      = '0;
        pm_new    = 1'b0;
        day_carry = 1'b0;
        if (hr24_mode) begin
            hval = code_to_bin(cur, bin_mode);
            if (hval >= VAL_W'(23)) begin
                hnew      = '0;
                day_carry = 1'b1;
            end else begin
                hnew = hval + VAL_W'(1);
            end
            nxt = bin_to_code(hnew, bin_mode);
        end else begin
            hval   = code_to_bin({1'b0, cur[6:0]}, bin_mode);
            pm_new = cur[7];
            if (hval == VAL_W'(11)) begin
                hnew      = VAL_W'(12);
                pm_new    = ~cur[7];
                day_carry = cur[7];
            end else if (hval >= VAL_W'(12)) begin
                hnew = VAL_W'(1);
            end else begin
                hnew = hval + VAL_W'(1);
            end
            nxt = bin_to_code(hnew, bin_mode) | {pm_new, 7'd0};
        end
    end

endmodule

// File: rtl/tod_month_len.sv
// Module tod_month_len
// Returns the last day of the month held in `month`, decoded in the
// active coding. Leap years are not modelled, so February always has 28.
// Assumes month is 1..12. Any other value yields 31.
module tod_month_len
    import tod_pkg::*;
(
    input  logic [DATA_W-1:0] month,
    input  logic              bin_mode,
    output logic [VAL_W-1:0]  last_day
);

    logic [VAL_W-1:0] mval;

    // Fixed month-length lookup.
    always_comb begin
        mval = code_to_bin(month, bin_mode);
        case (mval)
            VAL_W'(2):                                   last_day = VAL_W'(28);
            VAL_W'(4), VAL_W'(6), VAL_W'(9), VAL_W'(11): last_day = VAL_W'(30);
            default:                                     last_day = VAL_W'(31);
        endcase
    end

endmodule

// File: rtl/tod_calendar_counter.sv
// Module tod_calendar_counter
// Ten-byte calendar/time-of-day counter. An accepted tick raises busy,
// waits LEAD_CYC cycles, then advances one field per cycle from seconds
// to year. A carry moves upward only when a field wraps. The block ends
// each update with an upd_done pulse and, on an alarm match, an
// alarm_hit pulse.
// Assumes sec_tick is a one-cycle pulse at most once per update and
// that software loads only values that are valid for the active modes.
module tod_calendar_counter
    import tod_pkg::*;
#(
    parameter int LEAD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bin_mode,
    input  logic              hr24_mode,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              upd_done,
    output logic              alarm_hit
);

    localparam int LCW = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;

    tod_step_e         state_q;
    logic [LCW-1:0]    lead_q;
    logic              carry_q;
    logic [DATA_W-1:0] tod_q [0:NREG-1];

    logic [DATA_W-1:0] f_cur  [FIELD_N];
    logic [VAL_W-1:0]  f_lo   [FIELD_N];
    logic [VAL_W-1:0]  f_hi   [FIELD_N];
    logic [DATA_W-1:0] f_nxt  [FIELD_N];
    logic [FIELD_N-1:0] f_wrap;

    logic [VAL_W-1:0]  mon_last;
    logic [DATA_W-1:0] hour_nxt;
    logic              hour_carry;
    logic [DATA_W-1:0] dow_nxt;
    logic              alarm_eq;
    logic              wr_alarm;
    logic              wr_in_range;

    // Route each generic field to its incrementer with its bounds.
    always_comb begin
        f_cur[F_SEC] = tod_q[IX_SEC];  f_lo[F_SEC] = '0;          f_hi[F_SEC] = VAL_W'(59);
        f_cur[F_MIN] = tod_q[IX_MIN];  f_lo[F_MIN] = '0;          f_hi[F_MIN] = VAL_W'(59);
        f_cur[F_DOM] = tod_q[IX_DOM];  f_lo[F_DOM] = VAL_W'(1);   f_hi[F_DOM] = mon_last;
        f_cur[F_MON] = tod_q[IX_MON];  f_lo[F_MON] = VAL_W'(1);   f_hi[F_MON] = VAL_W'(12);
        f_cur[F_YR]  = tod_q[IX_YEAR]; f_lo[F_YR]  = '0;          f_hi[F_YR]  = VAL_W'(99);
    end

    for (genvar g = 0; g < FIELD_N; g++) begin : g_field
        tod_field_inc u_inc (
            .cur      (f_cur[g]),
            .bin_mode (bin_mode),
            .lo       (f_lo[g]),
            .hi       (f_hi[g]),
            .nxt      (f_nxt[g]),
            .wrap     (f_wrap[g])
        );
    end

    tod_month_len u_mlen (
        .month    (tod_q[IX_MON]),
        .bin_mode (bin_mode),
        .last_day (mon_last)
    );

    tod_hour_inc u_hour (
        .cur       (tod_q[IX_HOUR]),
        .bin_mode  (bin_mode),
        .hr24_mode (hr24_mode),
        .nxt       (hour_nxt),
        .day_carry (hour_carry)
    );

    // Weekday 1..7 has the same code in both codings.
    assign dow_nxt = (tod_q[IX_DOW] >= DATA_W'(7)) ? DATA_W'(1) : tod_q[IX_DOW] + DATA_W'(1);

    // Compare the time bytes with their alarm bytes.
    assign alarm_eq = (tod_q[IX_SEC]  == tod_q[IX_ASEC]) &&
                      (tod_q[IX_MIN]  == tod_q[IX_AMIN]) &&
                      (tod_q[IX_HOUR] == tod_q[IX_AHOUR]);

    assign wr_in_range = (wr_idx < IDX_W'(NREG));
    assign wr_alarm    = wr_idx[0] && (wr_idx <= IDX_W'(IX_AHOUR));

    // Update sequencer, field registers and host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lead_q    <= '0;
            carry_q   <= 1'b0;
            upd_done  <= 1'b0;
            alarm_hit <= 1'b0;
            for (int i = 0; i < NREG; i++) tod_q[i] <= '0;
            tod_q[IX_DOW] <= DATA_W'(1);
            tod_q[IX_DOM] <= DATA_W'(1);
            tod_q[IX_MON] <= DATA_W'(1);
        end else begin
            upd_done  <= 1'b0;
            alarm_hit <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (sec_tick && !hold) begin
                        state_q <= ST_LEAD;
                        lead_q  <= LCW'(LEAD_CYC - 1);
                    end
                end
                ST_LEAD: begin
                    if (lead_q == '0) state_q <= ST_SEC;
                    else              lead_q  <= lead_q - LCW'(1);
                end
                ST_SEC: begin
                    tod_q[IX_SEC] <= f_nxt[F_SEC];
                    carry_q       <= f_wrap[F_SEC];
                    state_q       <= ST_MIN;
                end
                ST_MIN: begin
                    if (carry_q) begin
                        tod_q[IX_MIN] <= f_nxt[F_MIN];
                        carry_q       <= f_wrap[F_MIN];
                    end
                    state_q <= ST_HOUR;
                end
                ST_HOUR: begin
                    if (carry_q) begin
                        tod_q[IX_HOUR] <= hour_nxt;
                        carry_q        <= hour_carry;
                    end
                    state_q <= ST_DAY;
                end
                ST_DAY: begin
                    if (carry_q) begin
                        tod_q[IX_DOW] <= dow_nxt;
                        tod_q[IX_DOM] <= f_nxt[F_DOM];
                        carry_q       <= f_wrap[F_DOM];
                    end
                    state_q <= ST_MON;
                end
                ST_MON: begin
                    if (carry_q) begin
                        tod_q[IX_MON] <= f_nxt[F_MON];
                        carry_q       <= f_wrap[F_MON];
                    end
                    state_q <= ST_YEAR;
                end
                ST_YEAR: begin
                    if (carry_q) begin
                        tod_q[IX_YEAR] <= f_nxt[F_YR];
                        carry_q        <= f_wrap[F_YR];
                    end
                    state_q <= ST_END;
                end
                ST_END: begin
                    state_q   <= ST_IDLE;
                    upd_done  <= 1'b1;
                    alarm_hit <= alarm_eq;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (wr_en && wr_in_range && (wr_alarm || (hold && state_q == ST_IDLE)))
                tod_q[wr_idx] <= wr_data;
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign rd_data = (rd_idx < IDX_W'(NREG)) ? tod_q[rd_idx] : '0;

    // R7
    hold_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(hold));

    // R8
    sec_moves_only_by_step_or_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tod_q[IX_SEC]) |-> ($past(state_q) == ST_SEC || ($past(wr_en) && $past(hold))));

    // R9
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (!busy && $past(busy)));

    // R10
    alarm_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);

    // R12
    no_restart_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_END) |=> busy);

endmodule

// File: tb/tod_calendar_counter_bench.sv
`timescale 1ns/1ps
module tod_calendar_counter_bench;

    localparam int LEAD = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sec_tick, bin_mode, hr24_mode, hold, wr_en;
    logic [3:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;
    logic       busy, upd_done, alarm_hit;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tod_calendar_counter #(.LEAD_CYC(LEAD)) u_tod_calendar_counter (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bin_mode(bin_mode),
        .hr24_mode(hr24_mode), .hold(hold), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy),
        .upd_done(upd_done), .alarm_hit(alarm_hit)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] idx, output logic [7:0] v);
        rd_idx = idx;
        #1;
        v = rd_data;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] idx, input logic [7:0] exp);
        logic [7:0] v;
        peek(idx, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Load seconds, minutes and hours with hold raised.
    task automatic load_hms(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        hold = 1'b1;
        wr(4'd0, s); wr(4'd2, m); wr(4'd4, h);
        hold = 1'b0;
    endtask

    task automatic do_tick(output logic done, output logic alm);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        done = upd_done;
        alm  = alarm_hit;
    endtask

    task automatic t_reset;
        chk("R1 busy", {7'd0, busy}, 8'h00);
        chk("R1 upd_done", {7'd0, upd_done}, 8'h00);
        chk("R1 alarm_hit", {7'd0, alarm_hit}, 8'h00);
        for (int i = 0; i < 10; i++)
            expect_reg("R1 R2 reset value", 4'(i), (i >= 6 && i <= 8) ? 8'h01 : 8'h00);
        expect_reg("R2 index 12 reads zero", 4'd12, 8'h00);
    endtask

    task automatic t_bcd_rollover;
        logic d, a;
        bin_mode = 1'b0; hr24_mode = 1'b1;
        hold = 1'b1;
        wr(4'd0, 8'h58); wr(4'd2, 8'h59); wr(4'd4, 8'h23);
        wr(4'd6, 8'h07); wr(4'd7, 8'h31); wr(4'd8, 8'h12); wr(4'd9, 8'h99);
        hold = 1'b0;
        do_tick(d, a);
        chk("R9 done pulse", {7'd0, d}, 8'h01);
        expect_reg("R3 sec step", 4'd0, 8'h59);
        expect_reg("R3 min kept", 4'd2, 8'h59);
        @(negedge clk);
        chk("R9 done one cycle", {7'd0, upd_done}, 8'h00);
        do_tick(d, a);
        expect_reg("R3 sec wrap bcd", 4'd0, 8'h00);
        expect_reg("R3 min wrap bcd", 4'd2, 8'h00);
        expect_reg("R4 hour 23 to 0", 4'd4, 8'h00);
        expect_reg("R6 weekday 7 to 1", 4'd6, 8'h01);
        expect_reg("R6 dom 31 to 1", 4'd7, 8'h01);
        expect_reg("R6 month 12 to 1", 4'd8, 8'h01);
        expect_reg("R6 year 99 to 0", 4'd9, 8'h00);
    endtask

    task automatic t_month_len;
        logic d, a;
        hold = 1'b1;
        wr(4'd7, 8'h30); wr(4'd8, 8'h04);
        hold = 1'b0;
        load_hms(8'h59, 8'h59, 8'h23);
        do_tick(d, a);
        expect_reg("R6 april ends at 30", 4'd7, 8'h01);
        expect_reg("R6 month 4 to 5", 4'd8, 8'h05);
        hold = 1'b1;
        wr(4'd7, 8'h30); wr(4'd8, 8'h01);
        hold = 1'b0;
        load_hms(8'h59, 8'h59, 8'h23);
        do_tick(d, a);
        expect_reg("R6 january reaches 31", 4'd7, 8'h31);
        expect_reg("R6 month held", 4'd8, 8'h01);
    endtask

    task automatic t_binary;
        logic d, a;
        bin_mode = 1'b1; hr24_mode = 1'b1;
        hold = 1'b1;
        wr(4'd7, 8'd28); wr(4'd8, 8'd2);
        hold = 1'b0;
        load_hms(8'd59, 8'd10, 8'd5);
        do_tick(d, a);
        expect_reg("R3 binary sec wrap", 4'd0, 8'h00);
        expect_reg("R3 binary min carry", 4'd2, 8'd11);
        expect_reg("R4 binary hour kept", 4'd4, 8'd5);
        load_hms(8'd59, 8'd59, 8'd23);
        do_tick(d, a);
        expect_reg("R4 binary hour wrap", 4'd4, 8'h00);
        expect_reg("R6 february ends at 28", 4'd7, 8'd1);
        expect_reg("R6 binary month", 4'd8, 8'd3);
        bin_mode = 1'b0;
    endtask

    task automatic t_twelve_hour;
        logic d, a;
        bin_mode = 1'b0; hr24_mode = 1'b0;
        hold = 1'b1;
        wr(4'd7, 8'h05); wr(4'd8, 8'h03);
        hold = 1'b0;
        load_hms(8'h59, 8'h59, 8'h11);
        do_tick(d, a);
        expect_reg("R5 11am to 12pm", 4'd4, 8'h92);
        expect_reg("R5 no day carry at noon", 4'd7, 8'h05);
        load_hms(8'h59, 8'h59, 8'h92);
        do_tick(d, a);
        expect_reg("R5 12pm to 1pm", 4'd4, 8'h81);
        load_hms(8'h59, 8'h59, 8'h91);
        do_tick(d, a);
        expect_reg("R5 11pm to 12am", 4'd4, 8'h12);
        expect_reg("R5 midnight day carry", 4'd7, 8'h06);
        load_hms(8'h59, 8'h59, 8'h12);
        do_tick(d, a);
        expect_reg("R5 12am to 1am", 4'd4, 8'h01);
        expect_reg("R5 day kept", 4'd7, 8'h06);
        hr24_mode = 1'b1;
    endtask

    task automatic t_hold;
        logic d, a;
        load_hms(8'h20, 8'h00, 8'h00);
        hold = 1'b1;
        do_tick(d, a);
        chk("R7 tick under hold no done", {7'd0, d}, 8'h00);
        chk("R7 tick under hold not busy", {7'd0, busy}, 8'h00);
        expect_reg("R7 sec frozen", 4'd0, 8'h20);
        hold = 1'b0;
        wr(4'd0, 8'h11);
        expect_reg("R7 time write without hold dropped", 4'd0, 8'h20);
        wr(4'd3, 8'h42);
        expect_reg("R7 alarm write without hold taken", 4'd3, 8'h42);
    endtask

    task automatic t_lead_and_retick;
        logic rose;
        load_hms(8'h40, 8'h00, 8'h00);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        for (int i = 0; i < LEAD; i++) begin
            chk("R8 busy in lead window", {7'd0, busy}, 8'h01);
            expect_reg("R8 sec unchanged in lead", 4'd0, 8'h40);
            if (i == 0) sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
        for (int i = 0; i < 60; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        expect_reg("R12 single advance", 4'd0, 8'h41);
        rose = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (busy) rose = 1'b1;
        end
        chk("R12 no second update", {7'd0, rose}, 8'h00);
    endtask

    task automatic t_alarm;
        logic d, a;
        wr(4'd1, 8'h30); wr(4'd3, 8'h10); wr(4'd5, 8'h08);
        load_hms(8'h29, 8'h10, 8'h08);
        do_tick(d, a);
        chk("R10 match done", {7'd0, d}, 8'h01);
        chk("R10 alarm on match", {7'd0, a}, 8'h01);
        do_tick(d, a);
        chk("R10 no alarm off match", {7'd0, a}, 8'h00);
    endtask

    task automatic t_mode_switch;
        hold = 1'b1;
        wr(4'd0, 8'h45);
        hold = 1'b0;
        wr(4'd1, 8'h27);
        bin_mode = 1'b1; hr24_mode = 1'b0;
        @(negedge clk);
        expect_reg("R11 sec not converted", 4'd0, 8'h45);
        expect_reg("R11 alarm not converted", 4'd1, 8'h27);
        bin_mode = 1'b0; hr24_mode = 1'b1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sec_tick = 1'b0; bin_mode = 1'b0; hr24_mode = 1'b1;
        hold = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bcd_rollover();
        t_month_len();
        t_binary();
        t_twelve_hour();
        t_hold();
        t_lead_and_retick();
        t_alarm();
        t_mode_switch();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule